// File: doc/BRIEF.md
# Dual-Line Serial ADC Capture

This block reads a pair of 12-bit serial converters that share one active-low select line and one serial clock, while each converter returns its bits on its own data line. A single frame therefore captures both channels at once. A one-cycle start request opens a frame. The block then produces the serial clock by dividing the system clock, shifts both data lines in on rising serial-clock edges, and publishes both results together with a one-cycle done pulse.

Each published result carries one extra zero bit above the 12 data bits, giving a 13-bit word. Later arithmetic can therefore subtract two results and read the difference as two's complement without losing the sign. The block also makes a free-running conversion-rate tick, with its period set by parameters (by default about ten ticks a second). A system can wire this tick to the start request to sample at a steady rate.

Top module: `dual_adc_capture`

## Requirements
- R1: While reset is asserted, and until the first start after reset, the select output is high, the serial clock is high, busy and done are low and both results are zero.
- R2: A start pulse seen while idle drives the select low and busy high in the cycle right after the clock edge that captured the start.
- R3: With the select low, the serial clock starts high, falls SCLK_DIV/2 system cycles after the select falls, and then alternates every SCLK_DIV/2 cycles. It gives exactly 16 rising edges per frame, and the select returns high on the 16th. While the select is high, the serial clock stays high.
- R4: Both data lines are sampled on every rising serial-clock edge, most significant bit first. Each result is the last 12 bits received on its line, placed in bits 11..0 with bit 12 forced to zero, and both results change in the same cycle.
- R5: The first 4 bits received in a frame are discarded: their values never reach a result.
- R6: Done is high for exactly one cycle, the cycle in which the select returns high and the results take their new values. Outside that cycle the results hold.
- R7: After a frame the select stays high for SCLK_DIV system cycles with busy still high, and then busy falls. A start that arrives while busy is ignored.
- R8: The rate tick is a one-cycle pulse that repeats every CLK_HZ/RATE_HZ system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a frame |
| busy | output | 1 | A frame or the guard gap after it is in progress |
| done | output | 1 | One-cycle pulse when fresh results are published |
| adc_cs_n | output | 1 | Active-low select shared by both converters |
| adc_sclk | output | 1 | Serial clock to both converters, idles high |
| adc_sd_a | input | 1 | Serial data line from converter A |
| adc_sd_b | input | 1 | Serial data line from converter B |
| res_a | output | 13 | Channel A result, zero-extended by one bit |
| res_b | output | 13 | Channel B result, zero-extended by one bit |
| rate_tick | output | 1 | Conversion-rate pulse |

## Verification
The two lines get a walking one against a walking zero. This separates the channels from each other and shows any bit-position slip or reversal in the shift order. Frames that carry ones in the four leading positions show whether those bits leak into a result. A long pseudo-random sweep with independent words on the two lines finds cross-coupling and stale-result faults. Every frame is also checked cycle by cycle against a waveform worked out by arithmetic, and some frames carry extra start pulses in mid-frame and in the guard gap to show that a busy block ignores them.

// File: rtl/adcc_pkg.sv
package adcc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } adcc_state_e;
endpackage

// File: rtl/adcc_rate_tick.sv
module adcc_rate_tick #(
  parameter int PERIOD = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;
  logic          tick_d;

  assign wrap = (cnt_q == CW'(PERIOD - 1));

  always_comb begin
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    tick_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tick  <= tick_d;
    end
  end
endmodule

// File: rtl/adcc_sclk_gen.sv
module adcc_sclk_gen #(
  parameter int HALF = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HW-1:0] hc_q, hc_d;
  logic          sclk_d;
  logic          half_end;

  assign half_end = run && (hc_q == HW'(HALF - 1));
  assign rise     = half_end && !sclk;

  always_comb begin
    if (!run) begin
      hc_d   = '0;
      sclk_d = 1'b1;
    end else if (half_end) begin
      hc_d   = '0;
      sclk_d = ~sclk;
    end else begin
      hc_d   = hc_q + 1'b1;
      sclk_d = sclk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q <= '0;
      sclk <= 1'b1;
    end else begin
      hc_q <= hc_d;
      sclk <= sclk_d;
    end
  end
endmodule

// File: rtl/adcc_chan.sv
module adcc_chan #(
  parameter int DATA_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            cap,
  input  logic            sd,
  output logic [DATA_W:0] res
);
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W:0]   res_d;

  always_comb begin
    sh_d  = {sh_q[DATA_W-2:0], sd};
    res_d = {1'b0, sh_d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (shift_en) begin
      sh_q <= sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0;
    end else if (cap) begin
      res <= res_d;
    end
  end
endmodule

// File: rtl/adcc_frame_ctrl.sv
module adcc_frame_ctrl
  import adcc_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int GAP_CYC    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rise,
  output logic run,
  output logic busy,
  output logic cs_n,
  output logic last,
  output logic done
);
  localparam int BW = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
  localparam int GW = (GAP_CYC > 2) ? $clog2(GAP_CYC) : 1;

  adcc_state_e   st_q, st_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          cs_d, done_d;

  assign run  = (st_q == ST_XFER);
  assign busy = (st_q != ST_IDLE);
  assign last = run && rise && (bit_q == BW'(FRAME_BITS - 1));

  always_comb begin
    st_d   = st_q;
    bit_d  = bit_q;
    gap_d  = gap_q;
    cs_d   = cs_n;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_XFER;
          cs_d  = 1'b0;
          bit_d = '0;
        end
      end
      ST_XFER: begin
        if (rise) bit_d = bit_q + 1'b1;
        if (last) begin
          st_d   = ST_GAP;
          cs_d   = 1'b1;
          done_d = 1'b1;
          gap_d  = '0;
        end
      end
      ST_GAP: begin
        if (gap_q == GW'(GAP_CYC - 1)) st_d = ST_IDLE;
        else                           gap_d = gap_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
      gap_q <= '0;
      cs_n  <= 1'b1;
      done  <= 1'b0;
    end else begin
      st_q  <= st_d;
      bit_q <= bit_d;
      gap_q <= gap_d;
      cs_n  <= cs_d;
      done  <= done_d;
    end
  end
endmodule

// File: rtl/dual_adc_capture.sv
module dual_adc_capture #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int RATE_HZ    = 10,
  parameter int SCLK_DIV   = 16,
  parameter int DATA_W     = 12,
  parameter int LEAD_BITS  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic            adc_cs_n,
  output logic            adc_sclk,
  input  logic            adc_sd_a,
  input  logic            adc_sd_b,
  output logic [DATA_W:0] res_a,
  output logic [DATA_W:0] res_b,
  output logic            rate_tick
);
  localparam int FRAME_BITS = LEAD_BITS + DATA_W;
  localparam int HALF       = SCLK_DIV / 2;
  localparam int PERIOD     = CLK_HZ / RATE_HZ;
  localparam int NCH        = 2;

  logic            rst_meta, rst_sync;
  logic            run, rise, last, shift_en;
  logic [NCH-1:0]  sd_vec;
  logic [DATA_W:0] res_vec [NCH];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  adcc_rate_tick #(.PERIOD(PERIOD)) u_rate (
    .clk(clk), .rst_n(rst_sync), .tick(rate_tick)
  );

  adcc_sclk_gen #(.HALF(HALF)) u_sclk (
    .clk(clk), .rst_n(rst_sync), .run(run), .sclk(adc_sclk), .rise(rise)
  );

  adcc_frame_ctrl #(.FRAME_BITS(FRAME_BITS), .GAP_CYC(SCLK_DIV)) u_ctrl (
    .clk(clk), .rst_n(rst_sync), .start(start), .rise(rise), .run(run),
    .busy(busy), .cs_n(adc_cs_n), .last(last), .done(done)
  );

  assign shift_en = run && rise;
  assign sd_vec   = {adc_sd_b, adc_sd_a};

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    adcc_chan #(.DATA_W(DATA_W)) u_chan (
      .clk(clk), .rst_n(rst_sync), .shift_en(shift_en), .cap(last),
      .sd(sd_vec[g]), .res(res_vec[g])
    );
  end

  assign res_a = res_vec[0];
  assign res_b = res_vec[1];
endmodule

// File: rtl/adcc_chk.sv
module adcc_chk #(
  parameter int OUT_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             adc_cs_n,
  input logic             adc_sclk,
  input logic [OUT_W-1:0] res_a,
  input logic [OUT_W-1:0] res_b,
  input logic             rate_tick
);
  // R3
  sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> adc_sclk);

  // R2
  sel_low_only_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> $rose(busy));

  // R7
  sel_high_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> adc_cs_n);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_with_sel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (adc_cs_n && $rose(adc_cs_n)));

  // R6
  results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_a) && $stable(res_b)));

  // R4
  top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!res_a[OUT_W-1] && !res_b[OUT_W-1]));

  // R8
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_tick |=> !rate_tick);
endmodule

bind dual_adc_capture adcc_chk #(.OUT_W(DATA_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .res_a(res_a), .res_b(res_b),
  .rate_tick(rate_tick)
);

// File: tb/dual_adc_capture_test.sv
`timescale 1ns/1ps
module dual_adc_capture_test;
  localparam int DIV    = 4;
  localparam int H      = DIV / 2;
  localparam int XFER   = 16 * DIV;
  localparam int CLKHZ  = 2000;
  localparam int RATEHZ = 10;
  localparam int TPER   = CLKHZ / RATEHZ;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        adc_sd_a = 1'b0, adc_sd_b = 1'b0;
  logic        busy, done, adc_cs_n, adc_sclk, rate_tick;
  logic [12:0] res_a, res_b;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int nb = -1;
  logic [15:0] word_a = '0, word_b = '0;
  logic [12:0] exp_a = '0, exp_b = '0;

  always #2.5 clk = ~clk;

  dual_adc_capture #(.CLK_HZ(CLKHZ), .RATE_HZ(RATEHZ), .SCLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sd_a(adc_sd_a),
    .adc_sd_b(adc_sd_b), .res_a(res_a), .res_b(res_b), .rate_tick(rate_tick)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // converter model: next bit on each falling serial-clock edge
  initial forever begin
    @(negedge adc_sclk);
    if (nb >= 0) begin
      adc_sd_a = word_a[nb];
      adc_sd_b = word_b[nb];
      nb--;
    end
  end

  // R8 rate tick spacing
  initial begin
    int last_t;
    int cyc;
    last_t = -1;
    cyc = 0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      cyc++;
      if (rate_tick) begin
        if (last_t >= 0) chk((cyc - last_t) == TPER, "R8 tick spacing", cyc - last_t, TPER);
        last_t = cyc;
      end
    end
  end

  task automatic run_frame(input logic [15:0] wa, input logic [15:0] wb, input bit poke);
    logic [12:0] pa, pb, ea, eb;
    int rises, bad_wave, bad_done, bad_busy;
    logic prev_sc;
    pa = exp_a; pb = exp_b;
    ea = {1'b0, wa[11:0]};
    eb = {1'b0, wb[11:0]};
    word_a = wa; word_b = wb; nb = 15;
    rises = 0; bad_wave = -1; bad_done = -1; bad_busy = -1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    prev_sc = 1'b1;
    for (int n = 0; n < XFER + DIV + 4; n++) begin
      logic e_cs, e_sc;
      e_cs = (n < XFER) ? 1'b0 : 1'b1;
      e_sc = (n < XFER) ? (((n / H) % 2) == 0) : 1'b1;
      if ((adc_cs_n !== e_cs || adc_sclk !== e_sc) && bad_wave < 0) bad_wave = n;
      if (adc_sclk === 1'b1 && prev_sc === 1'b0) rises++;
      prev_sc = adc_sclk;
      if (done !== (n == XFER) && bad_done < 0) bad_done = n;
      if (busy !== (n < XFER + DIV) && bad_busy < 0) bad_busy = n;
      if (n == 0) chk(adc_cs_n === 1'b0 && busy === 1'b1, "R2 select low and busy",
                      {adc_cs_n, busy}, 2'b01);
      if (n == XFER - 1) begin
        chk(res_a === pa, "R6 res_a hold", res_a, pa);
        chk(res_b === pb, "R6 res_b hold", res_b, pb);
      end
      if (n == XFER) begin
        chk(res_a === ea, "R4 R5 res_a", res_a, ea);
        chk(res_b === eb, "R4 R5 res_b", res_b, eb);
      end
      start = (poke && (n == 10 || n == XFER + 1)) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(rises == 16, "R3 rising edge count", rises, 16);
    chk(bad_wave < 0, "R3 R7 select and clock waveform, first bad cycle", bad_wave, -1);
    chk(bad_done < 0, "R6 done pulse, first bad cycle", bad_done, -1);
    chk(bad_busy < 0, "R7 busy span, first bad cycle", bad_busy, -1);
    exp_a = ea; exp_b = eb;
  endtask

  initial begin
    logic [31:0] lf;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(adc_cs_n === 1'b1 && adc_sclk === 1'b1 && busy === 1'b0 && done === 1'b0,
        "R1 control outputs in reset", {adc_cs_n, adc_sclk, busy, done}, 4'b1100);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(adc_cs_n === 1'b1 && adc_sclk === 1'b1 && busy === 1'b0 && done === 1'b0,
        "R1 control outputs after reset", {adc_cs_n, adc_sclk, busy, done}, 4'b1100);
    chk(res_a === 13'd0 && res_b === 13'd0, "R1 results zero", {res_a, res_b}, 0);

    // walking one on A, walking zero on B
    for (int i = 0; i < 12; i++) begin
      run_frame(16'h0001 << i, ~(16'h0001 << i) & 16'h0FFF, (i % 3) == 0);
    end
    // leading bits set: must not reach results (R5)
    run_frame(16'hF000, 16'hF000, 1'b0);
    run_frame(16'hFA5A, 16'h85A5, 1'b1);
    run_frame(16'h0FFF, 16'hFFFF, 1'b0);
    run_frame(16'h7800, 16'h0001, 1'b0);
    // pseudo-random sweep
    lf = 32'h1ACE_B00C;
    for (int k = 0; k < 150; k++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      run_frame(lf[15:0], lf[31:16], (k % 4) == 1);
    end
    // idle start ignored check window: no activity without start
    repeat (20) @(negedge clk);
    chk(adc_cs_n === 1'b1 && busy === 1'b0, "R7 stays idle without start",
        {adc_cs_n, busy}, 2'b10);
    repeat (3 * TPER) @(negedge clk);
    summary();
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    summary();
  end
endmodule